// File: doc/BRIEF.md
# Saturating Halfword Vector Subtract Unit

This unit executes one vector instruction: it subtracts a second 128-bit operand from a first as eight independent signed 16-bit lanes. Each lane's difference is clamped into the signed 16-bit range. The unit sits behind a register-file read stage. Each cycle it receives a 32-bit instruction word, the two operand vectors already fetched, and a valid strobe. It checks the word against its own encoding. On a match it registers the clamped result together with a write enable and the destination register index.

A sticky saturation flag accompanies the datapath. Any lane that clamps during an executed instruction sets the flag, and it stays set through later instructions that do not clamp. Only the dedicated clear input or reset drops it. The instruction affects no condition or integer carry/overflow state, and the unit has none.

Top module: `vsub_sat_unit`

## Requirements
- R1: A word matches when instr_i[31:26] equals 4 and instr_i[10:0] equals 1856 (0x740), whatever the register fields hold. A matching word with valid_i high gives wr_en_o high on the next clock edge.
- R2: When wr_en_o is high, wr_idx_o equals instr_i[25:21] of the word that was executed one cycle earlier.
- R3: Lane i (i = 0..7) occupies bits [127-16i : 112-16i], so lane 0 is the most significant halfword. When a lane's signed difference a - b fits in 16 bits, the result lane equals that difference.
- R4: A lane difference above 32767 yields 0x7FFF and one below -32768 yields 0x8000. For example, 0x8000 - 0x7FFF gives 0x8000 and 0x7FFF - 0x8000 gives 0x7FFF.
- R5: A non-matching word, or valid_i low, leaves wr_en_o low on the next edge and keeps res_o, wr_idx_o and sat_o unchanged.
- R6: sat_o rises on the same edge that delivers the result of an executed instruction in which at least one lane clamped.
- R7: Once set, sat_o stays high through executed instructions without clamping and through idle cycles until it is cleared.
- R8: sat_clr_i high clears sat_o on the next edge. If a clamping instruction executes in the same cycle as the clear, sat_o ends high.
- R9: While rst_n is low, res_o is zero, wr_en_o is low, wr_idx_o is zero and sat_o is low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction word and operands are valid this cycle |
| instr_i | input | 32 | Instruction word, bit 31 is the leading (most significant) bit |
| opa_i | input | 128 | Minuend vector, lane 0 in the top halfword |
| opb_i | input | 128 | Subtrahend vector, lane 0 in the top halfword |
| sat_clr_i | input | 1 | Synchronous clear of the sticky saturation flag |
| res_o | output | 128 | Registered clamped difference vector |
| wr_en_o | output | 1 | Destination write enable, one cycle after an executed instruction |
| wr_idx_o | output | 5 | Destination register index |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The assertions check four things on every cycle: the lane sign rules, which say that a non-negative minus a negative is never negative and the reverse; the link between a matching valid word and the next cycle's write enable and index; result stability when nothing executes; and the set, hold and clear behaviour of the saturation flag. Whether each clamped value and each in-range difference is numerically exact, and in the right lane, is shown only by the bench. The bench sweeps every pair from a set of boundary lane values through every lane position and runs a long pseudo-random stream. It also sweeps all 64 leading opcode values and all 2048 extended opcode values, which shows that only the one encoding executes.

// File: rtl/vsub_pkg.sv
package vsub_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned LANES     = 8;
  localparam int unsigned LANE_W    = 16;
  localparam int unsigned VEC_W     = LANES * LANE_W;
  localparam int unsigned REGIDX_W  = 5;
  localparam int unsigned PRIM_W    = 6;
  localparam int unsigned XOP_W     = 11;
  localparam logic [PRIM_W-1:0] PRIM_CODE = 6'd4;
  localparam logic [XOP_W-1:0]  XOP_CODE  = 11'd1856;

  typedef struct packed {
    logic                hit;
    logic [REGIDX_W-1:0] dst;
  } dec_t;
endpackage

// File: rtl/vsub_decode.sv
module vsub_decode
  import vsub_pkg::*;
(
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  localparam int unsigned PRIM_LSB = INSTR_W - PRIM_W;
  localparam int unsigned DST_LSB  = PRIM_LSB - REGIDX_W;

  logic prim_ok;
  logic xop_ok;

  always_comb begin
    prim_ok   = (instr_i[INSTR_W-1:PRIM_LSB] == PRIM_CODE);
    xop_ok    = (instr_i[XOP_W-1:0] == XOP_CODE);
    dec_o.hit = valid_i & prim_ok & xop_ok;
    dec_o.dst = instr_i[DST_LSB +: REGIDX_W];
  end
endmodule

// File: rtl/vsub_lane.sv
module vsub_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W:0] diff;

  always_comb begin
    diff  = {a_i[W-1], a_i} - {b_i[W-1], b_i};
    ovf_o = diff[W] ^ diff[W-1];
    if (ovf_o) res_o = diff[W] ? MAX_NEG : MAX_POS;
    else       res_o = diff[W-1:0];
  end

  // Sign rules: non-negative minus negative never negative, and the reverse (R4)
  always_comb begin
    if (!a_i[W-1] && b_i[W-1])
      assert_pos_minus_neg_R4: assert (!res_o[W-1]);
    if (a_i[W-1] && !b_i[W-1])
      assert_neg_minus_pos_R4: assert (res_o[W-1]);
  end
endmodule

// File: rtl/vsub_sat_flag.sv
module vsub_sat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic exec_i,
  input  logic ovf_i,
  input  logic clr_i,
  output logic sat_o
);
  logic sat_q;
  logic sat_d;

  always_comb begin
    sat_d = sat_q;
    if (clr_i)           sat_d = 1'b0;
    if (exec_i && ovf_i) sat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sat_q <= 1'b0;
    else        sat_q <= sat_d;
  end

  assign sat_o = sat_q;

  assert_sat_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !clr_i) |=> sat_q);
  assert_sat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(exec_i && ovf_i)) |=> !sat_q);
  assert_sat_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && ovf_i) |=> sat_q);
  assert_sat_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i && !clr_i) |=> $stable(sat_q));
endmodule

// File: rtl/vsub_sat_unit.sv
module vsub_sat_unit
  import vsub_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [VEC_W-1:0]    opa_i,
  input  logic [VEC_W-1:0]    opb_i,
  input  logic                sat_clr_i,
  output logic [VEC_W-1:0]    res_o,
  output logic                wr_en_o,
  output logic [REGIDX_W-1:0] wr_idx_o,
  output logic                sat_o
);
  dec_t                dec;
  logic [VEC_W-1:0]    lane_res;
  logic [LANES-1:0]    lane_ovf;
  logic                any_ovf;

  logic [VEC_W-1:0]    res_q,  res_d;
  logic                wen_q,  wen_d;
  logic [REGIDX_W-1:0] idx_q,  idx_d;

  vsub_decode u_dec (
    .valid_i (valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  // Lane 0 is the most significant halfword
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned HI = VEC_W - 1 - g * LANE_W;
    vsub_lane #(.W(LANE_W)) u_lane (
      .a_i   (opa_i[HI -: LANE_W]),
      .b_i   (opb_i[HI -: LANE_W]),
      .res_o (lane_res[HI -: LANE_W]),
      .ovf_o (lane_ovf[g])
    );
  end

  always_comb begin
    any_ovf = |lane_ovf;
    wen_d   = dec.hit;
    res_d   = res_q;
    idx_d   = idx_q;
    if (dec.hit) begin
      res_d = lane_res;
      idx_d = dec.dst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wen_q <= 1'b0;
      idx_q <= '0;
    end else begin
      res_q <= res_d;
      wen_q <= wen_d;
      idx_q <= idx_d;
    end
  end

  vsub_sat_flag u_sat (
    .clk    (clk),
    .rst_n  (rst_n),
    .exec_i (dec.hit),
    .ovf_i  (any_ovf),
    .clr_i  (sat_clr_i),
    .sat_o  (sat_o)
  );

  assign res_o    = res_q;
  assign wr_en_o  = wen_q;
  assign wr_idx_o = idx_q;

  assert_match_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && instr_i[31:26] == 6'd4 && instr_i[10:0] == 11'd1856) |=> wr_en_o);
  assert_write_has_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(valid_i));
  assert_dest_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_idx_o == $past(instr_i[25:21])));
  assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec.hit |=> ($stable(res_o) && !wr_en_o));
endmodule

// File: tb/tb_vsub_sat_unit.sv
module tb_vsub_sat_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid_i;
  logic [31:0]  instr_i;
  logic [127:0] opa_i, opb_i;
  logic         sat_clr_i;
  logic [127:0] res_o;
  logic         wr_en_o;
  logic [4:0]   wr_idx_o;
  logic         sat_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic         sat_exp = 1'b0;
  logic [127:0] res_exp = '0;
  logic [4:0]   idx_exp = '0;
  logic [31:0]  lcg = 32'h1234_5678;

  vsub_sat_unit dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         output logic ovf);
    logic [127:0] r = '0;
    ovf = 1'b0;
    for (int i = 0; i < 8; i++) begin
      int d;
      d = int'($signed(a[127-16*i -: 16])) - int'($signed(b[127-16*i -: 16]));
      if (d > 32767)       begin d = 32767;  ovf = 1'b1; end
      else if (d < -32768) begin d = -32768; ovf = 1'b1; end
      r[127-16*i -: 16] = d[15:0];
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] p, input logic [4:0] d,
                                     input logic [4:0] ra, input logic [4:0] rb,
                                     input logic [10:0] x);
    return {p, d, ra, rb, x};
  endfunction

  // Drive at negedge, check at the following negedge (one register stage)
  task automatic issue(input string req, input logic v, input logic [31:0] w,
                       input logic [127:0] a, input logic [127:0] b, input logic clr);
    logic ovf, hit;
    logic [127:0] r;
    @(negedge clk);
    valid_i = v; instr_i = w; opa_i = a; opb_i = b; sat_clr_i = clr;
    hit = v && w[31:26] == 6'd4 && w[10:0] == 11'd1856;
    r = model(a, b, ovf);
    if (clr) sat_exp = 1'b0;
    if (hit) begin
      res_exp = r; idx_exp = w[25:21];
      if (ovf) sat_exp = 1'b1;
    end
    @(negedge clk);
    chk({req, " wr_en"}, {127'd0, wr_en_o}, {127'd0, hit});
    chk({req, " res"}, res_o, res_exp);
    chk({req, " idx"}, {123'd0, wr_idx_o}, {123'd0, idx_exp});
    chk({req, " sat"}, {127'd0, sat_o}, {127'd0, sat_exp});
    valid_i = 1'b0; sat_clr_i = 1'b0;
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  function automatic logic [127:0] rvec();
    return {rnd(), rnd(), rnd(), rnd()};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] edge_v [9];
    logic [31:0] op;
    edge_v = '{16'h8000, 16'h8001, 16'hC000, 16'hFFFF, 16'h0000,
               16'h0001, 16'h4000, 16'h7FFE, 16'h7FFF};
    op = mk(6'd4, 5'd0, 5'd0, 5'd0, 11'd1856);
    rst_n = 1'b0; valid_i = 1'b0; instr_i = '0; opa_i = '0; opb_i = '0; sat_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 res", res_o, '0);
    chk("R9 wr_en", {127'd0, wr_en_o}, '0);
    chk("R9 idx", {123'd0, wr_idx_o}, '0);
    chk("R9 sat", {127'd0, sat_o}, '0);
    rst_n = 1'b1;

    // R4/R6: named corners, cleared between so each sets SAT afresh
    issue("R4 min-max", 1, op, {8{16'h8000}}, {8{16'h7FFF}}, 1);
    issue("R4 max-min", 1, op, {8{16'h7FFF}}, {8{16'h8000}}, 1);
    // R7: non-clamping instruction keeps SAT
    issue("R7 sticky", 1, op, {8{16'h0005}}, {8{16'h0003}}, 0);
    issue("R7 idle", 0, op, '0, '0, 0);
    // R8: clear alone, then clear together with clamp
    issue("R8 clear", 0, op, '0, '0, 1);
    issue("R8 clr+clamp", 1, op, {16'h7FFF, 112'd0}, {16'hFFFF, 112'd0}, 1);
    issue("R8 clear2", 1, op, '0, '0, 1);

    // R3/R4/R6: every boundary pair in every lane position
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        for (int l = 0; l < 8; l++) begin
          logic [127:0] a, b;
          a = rvec() & {8{16'h0FFF}};
          b = rvec() & {8{16'h0FFF}};
          a[127-16*l -: 16] = edge_v[i];
          b[127-16*l -: 16] = edge_v[j];
          issue("R3 R4 R6 edge", 1, op, a, b, 1'(l == 0));
        end

    // R2/R3: random stream with random register fields
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] w;
      w = rnd();
      issue("R2 R3 R7 rand", 1'(w[0] | w[1]),
            mk(6'd4, w[31:27], w[26:22], w[21:17], 11'd1856), rvec(), rvec(),
            1'(w[7:2] == 6'd0));
    end

    // R1/R5: all leading opcodes, then all extended opcodes
    for (int p = 0; p < 64; p++)
      issue("R1 R5 prim", 1, mk(6'(p), 5'd9, 5'd1, 5'd2, 11'd1856),
            {8{16'h8000}}, {8{16'h0001}}, 0);
    for (int x = 0; x < 2048; x++)
      issue("R1 R5 xop", 1, mk(6'd4, 5'(x), 5'd3, 5'd4, 11'(x)),
            {8{16'h7FFF}}, {8{16'hFFFF}}, 1'(x == 1000));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule